// File: doc/BRIEF.md
# Two-Level Peripheral Interrupt Aggregator

This block gathers interrupt events for a small controller in two levels. Four peripheral events are first caught in a secondary stage. These are the two timer overflows, a waveform generator event and a fifth compare module event. The secondary stage has its own pending and mask registers, and its pending register clears itself when software reads it. The timer pair is funnelled into one primary pending bit (TOVF). The waveform/compare pair goes into another (PI). Direct sources land straight in the primary pending registers: external interrupt, capture/compare channels and conversion done.

A request leaves the block only when its primary pending bit and its primary mask bit are both set. For a cascaded source, its secondary mask bit must also have been set when the event arrived. The lowest-numbered active bit wins. A per-source select bit steers the winner either to the normal vectored request output or to the transaction-server request output. A one-cycle acknowledge carrying the winner's index clears that primary pending bit. Software reaches the registers over a byte-wide bus. Read data is combinational, and a write takes effect at the next clock edge.

Address map: 0 lower primary pending (read only), 1 lower primary mask, 2 upper primary pending (read only), 3 upper primary mask, 4 secondary pending (read clears), 5 secondary mask, 6 lower select, 7 upper select. Primary index n maps to bit n of the 16-bit view {upper, lower}.

Top module: `irqc_top`

## Requirements
- R1: A pulse on sec_evt[0] (timer 1 overflow), sec_evt[1] (timer 2 overflow), sec_evt[2] (waveform generator) or sec_evt[3] (compare 5) sets secondary pending bit 0, 2, 4 or 6 respectively, whatever the secondary mask holds.
- R2: Secondary pending and mask bits 1, 3, 5 and 7 are reserved. They always read as 1, and a write stores nothing in them. Mask bits 0, 2, 4 and 6 keep the written value.
- R3: A bus read of address 4 returns the secondary pending contents and then clears bits 0, 2, 4 and 6. An event arriving in the same cycle as that read remains set afterwards.
- R4: Primary bit 13 (PI, bit 5 at address 2) is set by a waveform generator or compare 5 event only if that event's secondary mask bit (4 or 6) is set in that cycle.
- R5: Primary bit 0 (TOVF, bit 0 at address 0) is set by a timer 1 or timer 2 overflow only if that timer's secondary mask bit (0 or 2) is set in that cycle.
- R6: A primary pending bit raises a request only while its primary mask bit is 1. It stays pending while masked, so setting the mask later raises the request.
- R7: When several pending bits are enabled, req_idx gives the lowest-numbered one.
- R8: If the select bit of the winning index is 1, pts_req is asserted instead of irq_req. The two are never high together.
- R9: An ack pulse with ack_idx = n clears primary pending bit n at the next edge.
- R10: prim_evt[n] sets primary pending bit n for n in {1..12, 14}. prim_evt bits 0, 13 and 15 have no effect. Bit 15 is reserved: it reads 0 in the pending, mask and select registers.
- R11: After reset, all pending, mask and select bits are 0, the reserved secondary bits read 1 and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect at address 4) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| sec_evt | input | 4 | Cascaded event pulses: t1, t2, waveform, compare 5 |
| prim_evt | input | 16 | Direct event pulses, one per primary index |
| ack | input | 1 | Acknowledge pulse |
| ack_idx | input | 4 | Index being acknowledged |
| irq_req | output | 1 | Vectored interrupt request |
| pts_req | output | 1 | Transaction-server request |
| req_idx | output | 4 | Index of the winning source |

## Verification
The bench reads the secondary pending register in the same cycle as a new timer event. A design that clears after merging would lose that event, and the following read would show it gone. It raises cascaded events while the secondary mask is clear and checks that neither PI nor TOVF moves. A design that ORs raw events into the primary bits would set them anyway. It leaves bits pending under a cleared primary mask and then enables them, which catches designs that drop or never raise masked bits. It also checks a higher index left waiting behind a lower one, which exposes an inverted priority. A final check covers the select bit moving a request onto the transaction-server output.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    parameter int REG_W    = 8;
    parameter int SEC_N    = 4;
    parameter int PRIM_N   = 2 * REG_W;
    parameter int IDX_W    = $clog2(PRIM_N);
    parameter int ADDR_W   = 3;
    parameter int TOVF_BIT = 0;
    parameter int PI_BIT   = 13;
    parameter int RSV_BIT  = 15;

    // secondary source order inside the cascade
    parameter int SEC_T1 = 0;
    parameter int SEC_T2 = 1;
    parameter int SEC_WG = 2;
    parameter int SEC_C5 = 3;

    // primary bits that a direct event may set
    parameter logic [PRIM_N-1:0] DIRECT_SRC = ~((PRIM_N'(1) << TOVF_BIT) |
                                                (PRIM_N'(1) << PI_BIT) |
                                                (PRIM_N'(1) << RSV_BIT));
    parameter logic [PRIM_N-1:0] PRIM_VALID = ~(PRIM_N'(1) << RSV_BIT);

    typedef enum logic [ADDR_W-1:0] {
        A_PEND_LO = 3'd0,
        A_MASK_LO = 3'd1,
        A_PEND_HI = 3'd2,
        A_MASK_HI = 3'd3,
        A_SEC_PND = 3'd4,
        A_SEC_MSK = 3'd5,
        A_SEL_LO  = 3'd6,
        A_SEL_HI  = 3'd7
    } irqc_addr_e;

    typedef struct packed {
        logic [SEC_N-1:0] pend;
        logic [SEC_N-1:0] mask;
    } sec_state_t;

    typedef struct packed {
        logic [PRIM_N-1:0] pend;
        logic [PRIM_N-1:0] mask;
        logic [PRIM_N-1:0] sel;
    } prim_state_t;
endpackage

// File: rtl/irqc_sec_stage.sv
module irqc_sec_stage
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEC_N-1:0] sec_evt,
    input  logic             rd_clr,
    input  logic             mask_we,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] pend_view,
    output logic [REG_W-1:0] mask_view,
    output logic             pi_set,
    output logic             tovf_set
);
    sec_state_t st_d, st_q;
    logic [SEC_N-1:0] gated_evt_d;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            for (int i = 0; i < SEC_N; i++) begin
                st_d.mask[i] = wr_data[2*i];
            end
        end
        if (rd_clr) begin
            st_d.pend = '0;
        end
        // a fresh event survives a clearing read
        st_d.pend   = st_d.pend | sec_evt;
        gated_evt_d = sec_evt & st_q.mask;
        tovf_set    = gated_evt_d[SEC_T1] | gated_evt_d[SEC_T2];
        pi_set      = gated_evt_d[SEC_WG] | gated_evt_d[SEC_C5];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gi = 0; gi < SEC_N; gi++) begin : g_view
        assign pend_view[2*gi]   = st_q.pend[gi];
        assign pend_view[2*gi+1] = 1'b1;
        assign mask_view[2*gi]   = st_q.mask[gi];
        assign mask_view[2*gi+1] = 1'b1;

        AST_SEC_EVT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            sec_evt[gi] |=> st_q.pend[gi]); // R3
    end

    AST_SEC_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && sec_evt == '0) |=> st_q.pend == '0); // R3

    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && sec_evt == '0) |=> $stable(st_q.pend)); // R1
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
    import irqc_pkg::*;
(
    input  logic [PRIM_N-1:0] active,
    input  logic [PRIM_N-1:0] sel,
    output logic              irq_req,
    output logic              pts_req,
    output logic [IDX_W-1:0]  req_idx
);
    logic any_act;

    always_comb begin
        req_idx = '0;
        any_act = |active;
        // scan downward so the lowest set index is kept last
        for (int i = PRIM_N - 1; i >= 0; i--) begin
            if (active[i]) begin
                req_idx = IDX_W'(i);
            end
        end
        pts_req = any_act & sel[req_idx];
        irq_req = any_act & ~sel[req_idx];
    end
endmodule

// File: rtl/irqc_prim_stage.sv
module irqc_prim_stage
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIM_N-1:0] set_vec,
    input  logic [1:0]        mask_we,
    input  logic [1:0]        sel_we,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ack,
    input  logic [IDX_W-1:0]  ack_idx,
    output logic [PRIM_N-1:0] pend_q,
    output logic [PRIM_N-1:0] mask_q,
    output logic [PRIM_N-1:0] sel_q,
    output logic              irq_req,
    output logic              pts_req,
    output logic [IDX_W-1:0]  req_idx
);
    prim_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < 2; b++) begin
            if (mask_we[b]) st_d.mask[b*REG_W +: REG_W] = wr_data;
            if (sel_we[b])  st_d.sel[b*REG_W +: REG_W]  = wr_data;
        end
        st_d.mask = st_d.mask & PRIM_VALID;
        st_d.sel  = st_d.sel & PRIM_VALID;
        if (ack) begin
            st_d.pend[ack_idx] = 1'b0;
        end
        // a new event wins over a same-cycle acknowledge
        st_d.pend = (st_d.pend | set_vec) & PRIM_VALID;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;
    assign mask_q = st_q.mask;
    assign sel_q  = st_q.sel;

    irqc_arb u_arb (
        .active  (st_q.pend & st_q.mask),
        .sel     (st_q.sel),
        .irq_req (irq_req),
        .pts_req (pts_req),
        .req_idx (req_idx)
    );

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set_vec[ack_idx]) |=> !pend_q[$past(ack_idx)]); // R9

    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req || pts_req) |-> (pend_q[req_idx] && mask_q[req_idx])); // R6

    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req && pts_req)); // R8

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req || pts_req) |->
            ((pend_q & mask_q & ((PRIM_N'(1) << req_idx) - PRIM_N'(1))) == '0)); // R7

    AST_RSV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[RSV_BIT] && !mask_q[RSV_BIT] && !sel_q[RSV_BIT]); // R10
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [SEC_N-1:0]  sec_evt,
    input  logic [PRIM_N-1:0] prim_evt,
    input  logic              ack,
    input  logic [IDX_W-1:0]  ack_idx,
    output logic              irq_req,
    output logic              pts_req,
    output logic [IDX_W-1:0]  req_idx
);
    logic [REG_W-1:0]  sec_pend_view, sec_mask_view;
    logic              pi_set, tovf_set, sec_rd_clr, sec_mask_we;
    logic [1:0]        mask_we, sel_we;
    logic [PRIM_N-1:0] set_vec, pend_q, mask_q, sel_q;

    always_comb begin
        sec_rd_clr  = bus_rd && (bus_addr == A_SEC_PND);
        sec_mask_we = bus_wr && (bus_addr == A_SEC_MSK);
        mask_we     = {bus_wr && (bus_addr == A_MASK_HI), bus_wr && (bus_addr == A_MASK_LO)};
        sel_we      = {bus_wr && (bus_addr == A_SEL_HI),  bus_wr && (bus_addr == A_SEL_LO)};
        set_vec     = (prim_evt & DIRECT_SRC)
                    | (PRIM_N'(tovf_set) << TOVF_BIT)
                    | (PRIM_N'(pi_set) << PI_BIT);
        case (bus_addr)
            A_PEND_LO: bus_rdata = pend_q[REG_W-1:0];
            A_MASK_LO: bus_rdata = mask_q[REG_W-1:0];
            A_PEND_HI: bus_rdata = pend_q[PRIM_N-1:REG_W];
            A_MASK_HI: bus_rdata = mask_q[PRIM_N-1:REG_W];
            A_SEC_PND: bus_rdata = sec_pend_view;
            A_SEC_MSK: bus_rdata = sec_mask_view;
            A_SEL_LO:  bus_rdata = sel_q[REG_W-1:0];
            default:   bus_rdata = sel_q[PRIM_N-1:REG_W];
        endcase
    end

    irqc_sec_stage u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_evt   (sec_evt),
        .rd_clr    (sec_rd_clr),
        .mask_we   (sec_mask_we),
        .wr_data   (bus_wdata),
        .pend_view (sec_pend_view),
        .mask_view (sec_mask_view),
        .pi_set    (pi_set),
        .tovf_set  (tovf_set)
    );

    irqc_prim_stage u_prim (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .mask_we (mask_we),
        .sel_we  (sel_we),
        .wr_data (bus_wdata),
        .ack     (ack),
        .ack_idx (ack_idx),
        .pend_q  (pend_q),
        .mask_q  (mask_q),
        .sel_q   (sel_q),
        .irq_req (irq_req),
        .pts_req (pts_req),
        .req_idx (req_idx)
    );

    AST_PI_NEEDS_SEC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q[PI_BIT] && !prim_evt[PI_BIT]) |=> (pend_q[PI_BIT] ==
            $past((sec_evt[SEC_WG] && sec_mask_view[2*SEC_WG]) ||
                  (sec_evt[SEC_C5] && sec_mask_view[2*SEC_C5])))); // R4

    AST_TOVF_NEEDS_SEC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[TOVF_BIT] |=> (pend_q[TOVF_BIT] ==
            $past((sec_evt[SEC_T1] && sec_mask_view[2*SEC_T1]) ||
                  (sec_evt[SEC_T2] && sec_mask_view[2*SEC_T2])))); // R5
endmodule

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
    localparam time CYC = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  sec_evt = '0;
    logic [15:0] prim_evt = '0;
    logic        ack = 1'b0;
    logic [3:0]  ack_idx = '0;
    logic        irq_req, pts_req;
    logic [3:0]  req_idx;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    typedef struct {
        bit         is_req;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #(CYC/2) clk = ~clk;

    irqc_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sec_evt(sec_evt), .prim_evt(prim_evt), .ack(ack), .ack_idx(ack_idx),
        .irq_req(irq_req), .pts_req(pts_req), .req_idx(req_idx)
    );

    // monitor: compares queued expectations mid low phase
    always @(negedge clk) begin
        #(CYC/4);
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            act = it.is_req ? {irq_req, pts_req, 2'b00, req_idx} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s %s actual=%h expected=%h", it.tag,
                         it.is_req ? "req" : "read", act, it.exp);
            end
        end
    end

    task automatic idle_strobes();
        bus_wr = 1'b0; bus_rd = 1'b0; sec_evt = '0; prim_evt = '0; ack = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); idle_strobes();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); idle_strobes();
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); idle_strobes();
        bus_addr = a; bus_rd = 1'b1;
        sb_q.push_back('{1'b0, exp, tag});
    endtask

    task automatic rd_evt(input logic [2:0] a, input logic [3:0] se,
                          input logic [7:0] exp, input string tag);
        @(negedge clk); idle_strobes();
        bus_addr = a; bus_rd = 1'b1; sec_evt = se;
        sb_q.push_back('{1'b0, exp, tag});
    endtask

    task automatic evt(input logic [3:0] se, input logic [15:0] pe);
        @(negedge clk); idle_strobes();
        sec_evt = se; prim_evt = pe;
    endtask

    task automatic do_ack(input logic [3:0] idx);
        @(negedge clk); idle_strobes();
        ack = 1'b1; ack_idx = idx;
    endtask

    task automatic chk_req(input bit irq, input bit pts, input logic [3:0] idx,
                           input string tag);
        @(negedge clk); idle_strobes();
        sb_q.push_back('{1'b1, {irq, pts, 2'b00, idx}, tag});
    endtask

    initial begin
        #(CYC * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state, R2 reserved secondary bits read 1
        rd(3'd0, 8'h00, "R11");
        rd(3'd1, 8'h00, "R11");
        rd(3'd2, 8'h00, "R11");
        rd(3'd3, 8'h00, "R11");
        rd(3'd4, 8'hAA, "R2");
        rd(3'd5, 8'hAA, "R2");
        rd(3'd6, 8'h00, "R11");
        rd(3'd7, 8'h00, "R11");
        chk_req(1'b0, 1'b0, 4'd0, "R11");

        // R1 all four events latch with the secondary mask clear
        evt(4'hF, 16'h0000);
        rd(3'd4, 8'hFF, "R1");
        rd(3'd4, 8'hAA, "R3");      // previous read cleared it
        rd(3'd0, 8'h00, "R5");      // no TOVF without secondary mask
        rd(3'd2, 8'h00, "R4");      // no PI without secondary mask

        // R2 mask write keeps only even bits
        wr(3'd5, 8'hFF);
        rd(3'd5, 8'hFF, "R2");
        wr(3'd5, 8'h10);            // waveform only
        rd(3'd5, 8'hBA, "R2");

        // R4 compare 5 masked out, waveform enabled
        evt(4'b1000, 16'h0000);
        rd(3'd2, 8'h00, "R4");
        evt(4'b0100, 16'h0000);
        rd(3'd2, 8'h20, "R4");
        rd(3'd4, 8'hFA, "R1");      // both events latched, then cleared

        // R5 timer 2 enabled only
        wr(3'd5, 8'h04);
        evt(4'b0001, 16'h0000);
        rd(3'd0, 8'h00, "R5");
        evt(4'b0010, 16'h0000);
        rd(3'd0, 8'h01, "R5");

        // R6 pending held while masked
        chk_req(1'b0, 1'b0, 4'd0, "R6");
        wr(3'd1, 8'h01);
        chk_req(1'b1, 1'b0, 4'd0, "R6");
        wr(3'd3, 8'h20);
        chk_req(1'b1, 1'b0, 4'd0, "R7");
        do_ack(4'd0);
        chk_req(1'b1, 1'b0, 4'd13, "R9");
        rd(3'd0, 8'h00, "R9");

        // R8 select moves request to the transaction server path
        wr(3'd7, 8'h20);
        chk_req(1'b0, 1'b1, 4'd13, "R8");
        do_ack(4'd13);
        chk_req(1'b0, 1'b0, 4'd0, "R9");

        // R3 event in the same cycle as the clearing read
        rd_evt(3'd4, 4'b0001, 8'hAF, "R3");
        rd(3'd4, 8'hAB, "R3");
        rd(3'd4, 8'hAA, "R3");

        // R10 direct sources, ignored bits 0, 13, 15
        evt(4'h0, 16'hFFFF);
        rd(3'd0, 8'hFE, "R10");
        rd(3'd2, 8'h5F, "R10");
        chk_req(1'b0, 1'b0, 4'd0, "R6");

        // R7 lowest enabled index wins
        wr(3'd1, 8'h0C);
        chk_req(1'b1, 1'b0, 4'd2, "R7");
        do_ack(4'd2);
        chk_req(1'b1, 1'b0, 4'd3, "R7");
        wr(3'd1, 8'h00);
        wr(3'd3, 8'h40);
        chk_req(1'b1, 1'b0, 4'd14, "R7");
        wr(3'd3, 8'hFF);
        rd(3'd3, 8'h7F, "R10");
        chk_req(1'b1, 1'b0, 4'd8, "R7");

        tick();
        tick();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule